// File: doc/BRIEF.md
# Narrow-to-Wide Bus Exchanger

This block joins a 12-bit narrow port (A) to a 24-bit wide port (B). The wide port is handled as two 12-bit halves: a low half (bits 11:0) and a high half (bits 23:12).

In the narrow-to-wide direction, each half of B has its own 12-bit capture register with its own active-low capture enable. Enabling the low half on one rising clock edge and the high half on the next edge builds two successive narrow words into one wide word.

In the wide-to-narrow direction, each half of B feeds its own level-sensitive hold latch. Each latch has an active-low open control. A half-select line picks which latch drives the narrow port, and this path does not use the clock.

Each port has an active-low output enable. The enable is reported as a data vector plus a drive bit, so that no tri-state net is needed.

Top module: `bus_exchanger`

## Requirements
- R1: On a rising clock edge with reset inactive, a capture register whose enable is low loads `a_in`. Enable bit 0 controls `b_out[11:0]` and enable bit 1 controls `b_out[23:12]`. The new value appears on `b_out` after that edge.
- R2: A capture register whose enable is high keeps its contents across clock edges, whatever `a_in` does.
- R3: Enabling bit 0 on one edge and bit 1 on the next edge, with different `a_in` words, puts the first word on `b_out[11:0]` and the second word on `b_out[23:12]` at the same time.
- R4: If both capture enables are low on the same edge, both halves of `b_out` take the same `a_in` word.
- R5: While a latch's open control is low (bit 0 for the low half of `b_in`, bit 1 for the high half), the latch follows its half of `b_in`. With that half selected, `a_out` follows that half of `b_in` without any clock edge.
- R6: While a latch's open control is high, the latch holds its last value, even when `b_in` changes.
- R7: `half_sel` = 0 routes the low-half latch to `a_out`; `half_sel` = 1 routes the high-half latch.
- R8: `a_drv` is the inverse of `a_oe_n` and `b_drv` is the inverse of `b_oe_n`. The output enables do not alter the `a_out` or `b_out` data.
- R9: A low `rst_n` at a rising edge clears both capture registers to zero; this reset wins over the capture enables. While `rst_n` is low, both latches are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Active-low reset (synchronous for the capture registers, level for the latches) |
| a_in | input | 12 | Narrow word arriving at port A |
| cap_en_n | input | 2 | Active-low capture enables; bit 0 is the low half, bit 1 is the high half |
| b_out | output | 24 | Wide word assembled from the capture registers |
| b_oe_n | input | 1 | Active-low output enable of port B |
| b_drv | output | 1 | High when port B is driven |
| b_in | input | 24 | Wide word arriving at port B |
| lat_en_n | input | 2 | Active-low latch open controls; bit 0 is the low half, bit 1 is the high half |
| half_sel | input | 1 | Picks the latch that drives A: 0 = low half, 1 = high half |
| a_out | output | 12 | Narrow word driven toward port A |
| a_oe_n | input | 1 | Active-low output enable of port A |
| a_drv | output | 1 | High when port A is driven |

## Verification
The capture path is driven with a low-only enable, a high-only enable, no enable, and both enables on one edge. The four results separate the per-half write, the hold, word assembly and duplicate writing. Distinct words are used on every edge, so a swapped half or a missed write shows up as a wrong value.

The latch path is first loaded with different values in each half. It is then read with both select values while `b_in` keeps changing, which separates transparency, hold and mux routing. A change of `b_in` with no clock edge shows that this path does not depend on the clock.

The output enables are toggled while data is held, which shows that they change only the drive bits. A reset applied in mid-run while both enables are low shows that reset takes priority.

// File: rtl/bx_pkg.sv
// Shared definitions for the bus exchanger.
// Assumes: the wide port is exactly two narrow halves.
package bx_pkg;
    localparam int unsigned NUM_HALVES = 2;

    // Identifies which wide half feeds the narrow port
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_sel_e;
endpackage

// File: rtl/bx_capture_reg.sv
// One narrow-to-wide capture register.
// Loads d on a rising edge when cap_n is low and holds otherwise.
// Assumes a synchronous active-low reset that wins over the enable.
module bx_capture_reg #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Purpose: clear on reset, load when enabled, otherwise keep
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (!cap_n) q <= d;
    end

    assert_capture_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_n |=> (q == $past(d)));

    assert_capture_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_n |=> $stable(q));

    assert_capture_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (q == '0));
endmodule

// File: rtl/bx_hold_latch.sv
// One wide-to-narrow transparent latch.
// Follows d while open_n is low and holds while open_n is high.
// Assumes rst_n low forces the contents to zero, at level and without the clock.
module bx_hold_latch #(
    parameter int unsigned W = 12
) (
    input  logic         rst_n,
    input  logic         open_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Purpose: level-sensitive storage with a clearing reset
    always_latch begin
        if (!rst_n)       q <= '0;
        else if (!open_n) q <= d;
    end
endmodule

// File: rtl/bx_half_mux.sv
// Picks one latched half for the narrow port.
// Assumes the select is an enum of the two halves.
module bx_half_mux
    import bx_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    input  half_sel_e    sel,
    output logic [W-1:0] y
);
    // Purpose: route the chosen half to the output
    always_comb begin
        unique case (sel)
            HALF_HI: y = hi;
            default: y = lo;
        endcase
    end
endmodule

// File: rtl/bus_exchanger.sv
// Narrow-to-wide bus exchanger top.
// Narrow-to-wide: clocked per-half capture registers.
// Wide-to-narrow: per-half latches followed by a half-select mux.
// Output enables appear as drive bits and never gate the data.
// Assumes index 0 of every per-half vector is the low half.
module bus_exchanger
    import bx_pkg::*;
#(
    parameter int unsigned HALF_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [HALF_W-1:0]              a_in,
    input  logic [NUM_HALVES-1:0]          cap_en_n,
    output logic [NUM_HALVES*HALF_W-1:0]   b_out,
    input  logic                           b_oe_n,
    output logic                           b_drv,
    input  logic [NUM_HALVES*HALF_W-1:0]   b_in,
    input  logic [NUM_HALVES-1:0]          lat_en_n,
    input  logic                           half_sel,
    output logic [HALF_W-1:0]              a_out,
    input  logic                           a_oe_n,
    output logic                           a_drv
);
    localparam int unsigned WIDE_W = NUM_HALVES * HALF_W;

    logic [HALF_W-1:0] lat_q [NUM_HALVES];
    half_sel_e         sel_e;

    // One capture register and one hold latch per wide half
    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        bx_capture_reg #(.W(HALF_W)) u_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .cap_n (cap_en_n[h]),
            .d     (a_in),
            .q     (b_out[h*HALF_W +: HALF_W])
        );

        bx_hold_latch #(.W(HALF_W)) u_lat (
            .rst_n  (rst_n),
            .open_n (lat_en_n[h]),
            .d      (b_in[h*HALF_W +: HALF_W]),
            .q      (lat_q[h])
        );
    end

    // Purpose: turn the raw select bit into the half enum
    always_comb sel_e = half_sel ? HALF_HI : HALF_LO;

    bx_half_mux #(.W(HALF_W)) u_mux (
        .lo  (lat_q[0]),
        .hi  (lat_q[1]),
        .sel (sel_e),
        .y   (a_out)
    );

    // Purpose: report the drive state of each port
    always_comb begin
        a_drv = ~a_oe_n;
        b_drv = ~b_oe_n;
    end

    assert_dup_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_en_n == '0) |=> (b_out[HALF_W-1:0] == b_out[WIDE_W-1:HALF_W]));

    assert_lo_transparent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_en_n[0] && !half_sel) |-> (a_out == b_in[HALF_W-1:0]));

    assert_hi_route_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lat_en_n[1] && half_sel) |-> (a_out == b_in[WIDE_W-1:HALF_W]));

    assert_drive_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe_n && b_oe_n) |-> (!a_drv && !b_drv));
endmodule

// File: tb/bus_exchanger_bench.sv
module bus_exchanger_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    typedef struct packed {
        logic [11:0] a;
        logic [1:0]  cen;
        logic [23:0] b;
        logic [1:0]  len;
        logic        sel;
        logic        aoe;
        logic        boe;
        logic [23:0] exp_b;
        logic [11:0] exp_a;
        logic        exp_adrv;
        logic        exp_bdrv;
        logic [3:0]  req;
    } vec_t;

    // Rows run in order; each depends on the stored state left by earlier rows.
    localparam vec_t VECS [NV] = '{
        '{12'h123, 2'b10, 24'h000000, 2'b11, 1'b0, 1'b0, 1'b0, 24'h000123, 12'h000, 1'b1, 1'b1, 4'd1}, // R1 low half
        '{12'h456, 2'b01, 24'h000000, 2'b11, 1'b0, 1'b0, 1'b0, 24'h456123, 12'h000, 1'b1, 1'b1, 4'd3}, // R3 assembly
        '{12'h789, 2'b11, 24'h000000, 2'b11, 1'b0, 1'b0, 1'b0, 24'h456123, 12'h000, 1'b1, 1'b1, 4'd2}, // R2 hold
        '{12'hABC, 2'b00, 24'h000000, 2'b11, 1'b0, 1'b0, 1'b0, 24'hABCABC, 12'h000, 1'b1, 1'b1, 4'd4}, // R4 both
        '{12'h000, 2'b11, 24'hDEF321, 2'b10, 1'b0, 1'b0, 1'b0, 24'hABCABC, 12'h321, 1'b1, 1'b1, 4'd5}, // R5 low open
        '{12'h000, 2'b11, 24'h111222, 2'b11, 1'b0, 1'b0, 1'b0, 24'hABCABC, 12'h321, 1'b1, 1'b1, 4'd6}, // R6 hold
        '{12'h000, 2'b11, 24'h5A50F0, 2'b01, 1'b1, 1'b0, 1'b0, 24'hABCABC, 12'h5A5, 1'b1, 1'b1, 4'd5}, // R5 high open
        '{12'h000, 2'b11, 24'h000000, 2'b11, 1'b0, 1'b0, 1'b0, 24'hABCABC, 12'h321, 1'b1, 1'b1, 4'd7}, // R7 sel 0
        '{12'h000, 2'b11, 24'h000000, 2'b11, 1'b1, 1'b0, 1'b0, 24'hABCABC, 12'h5A5, 1'b1, 1'b1, 4'd7}, // R7 sel 1
        '{12'h000, 2'b11, 24'h000000, 2'b11, 1'b1, 1'b1, 1'b0, 24'hABCABC, 12'h5A5, 1'b0, 1'b1, 4'd8}, // R8 A off
        '{12'hFFF, 2'b10, 24'h000000, 2'b11, 1'b1, 1'b0, 1'b1, 24'hABCFFF, 12'h5A5, 1'b1, 1'b0, 4'd8}, // R8 B off
        '{12'h000, 2'b11, 24'h876543, 2'b00, 1'b0, 1'b0, 1'b0, 24'hABCFFF, 12'h543, 1'b1, 1'b1, 4'd5}, // R5 both open
        '{12'h000, 2'b11, 24'h000000, 2'b11, 1'b1, 1'b0, 1'b0, 24'hABCFFF, 12'h876, 1'b1, 1'b1, 4'd6}  // R6 R7
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] a_in;
    logic [1:0]  cap_en_n;
    logic [23:0] b_out;
    logic        b_oe_n;
    logic        b_drv;
    logic [23:0] b_in;
    logic [1:0]  lat_en_n;
    logic        half_sel;
    logic [11:0] a_out;
    logic        a_oe_n;
    logic        a_drv;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_exchanger u_bus_exchanger (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_in     (a_in),
        .cap_en_n (cap_en_n),
        .b_out    (b_out),
        .b_oe_n   (b_oe_n),
        .b_drv    (b_drv),
        .b_in     (b_in),
        .lat_en_n (lat_en_n),
        .half_sel (half_sel),
        .a_out    (a_out),
        .a_oe_n   (a_oe_n),
        .a_drv    (a_drv)
    );

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 2000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; a_in = '0; cap_en_n = 2'b11; b_in = '0;
        lat_en_n = 2'b11; half_sel = 1'b0; a_oe_n = 1'b0; b_oe_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        // R9: reset state
        check(9, "reset b_out", 32'(b_out), 32'h0);
        check(9, "reset a_out", 32'(a_out), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: drive at the falling edge, check just after the next rising edge
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            a_in = VECS[i].a; cap_en_n = VECS[i].cen; b_in = VECS[i].b;
            lat_en_n = VECS[i].len; half_sel = VECS[i].sel;
            a_oe_n = VECS[i].aoe; b_oe_n = VECS[i].boe;
            @(posedge clk);
            #1;
            check(int'(VECS[i].req), $sformatf("row %0d b_out", i), 32'(b_out), 32'(VECS[i].exp_b));
            check(int'(VECS[i].req), $sformatf("row %0d a_out", i), 32'(a_out), 32'(VECS[i].exp_a));
            check(8, $sformatf("row %0d a_drv", i), 32'(a_drv), 32'(VECS[i].exp_adrv));
            check(8, $sformatf("row %0d b_drv", i), 32'(b_drv), 32'(VECS[i].exp_bdrv));
        end

        // R5: the latch path follows b_in with no clock edge
        @(negedge clk);
        cap_en_n = 2'b11; lat_en_n = 2'b10; half_sel = 1'b0; b_in = 24'h000ACE;
        #1;
        check(5, "async follow 1", 32'(a_out), 32'hACE);
        b_in = 24'h000BDF;
        #1;
        check(5, "async follow 2", 32'(a_out), 32'hBDF);
        lat_en_n = 2'b11;
        #1;
        b_in = 24'h000123;
        #1;
        // R6: hold after the latch closes, still with no clock edge
        check(6, "async hold", 32'(a_out), 32'hBDF);

        // R9: reset wins over both enables; latches are cleared
        @(negedge clk);
        rst_n = 1'b0; cap_en_n = 2'b00; a_in = 12'h777;
        @(posedge clk);
        #1;
        check(9, "reset over enable", 32'(b_out), 32'h0);
        check(9, "reset clears low latch", 32'(a_out), 32'h0);
        half_sel = 1'b1;
        #1;
        check(9, "reset clears high latch", 32'(a_out), 32'h0);
        @(negedge clk);
        rst_n = 1'b1; cap_en_n = 2'b11;
        @(posedge clk);
        #1;
        // R2: enables high after reset keep the cleared value
        check(2, "hold after reset", 32'(b_out), 32'h0);

        finish_run();
    end
endmodule